// File: doc/BRIEF.md
# Packed Neuron State Writer

This block updates the membrane potential of a single neuron in a banked on-chip state memory. Each memory word packs two neurons side by side. A write therefore cannot simply overwrite a word. The block fetches the word, replaces the half that belongs to the addressed neuron, and stores the full word again. The other neuron in the same word keeps its value.

A command enters on a valid/ready port and carries a neuron identifier and a signed voltage. The upper identifier bits select a memory bank. The lower bits select a word inside that bank, and the least significant bit selects the half of that word. While an update is in flight the block holds ready low, so a waiting command stays at the port until the block can take it. A one-cycle done pulse marks the end of each update.

Top module: `nstate_rmw`

## Requirements
- R1: After reset, cmd_ready is 1, and done, mem_rd_en and mem_wr_en are 0.
- R2: For a command with identifier id, mem_bank equals id >> LOCAL_W and mem_addr equals id[LOCAL_W-1:1]. Both values hold during the read strobe and during the write strobe.
- R3: If id[0] is 0 the voltage is written to word bits [V_W-1:0]. If id[0] is 1 it is written to bits [2*V_W-1:V_W].
- R4: The half of the word that is not targeted is written back exactly as it was read.
- R5: mem_rd_en pulses in the cycle after acceptance. mem_wr_en pulses two cycles after mem_rd_en, because read data arrives one cycle after the read strobe. done pulses for exactly one cycle, in the cycle after mem_wr_en.
- R6: cmd_ready is 0 from the cycle after acceptance through the done cycle. It is 1 only when the block is idle.
- R7: A command held valid while an update is in progress is not lost. It is accepted once the block is idle again and then executed.
- R8: Two consecutive commands to the even and odd neuron of the same word both persist in memory.
- R9: A negative voltage is stored as its full V_W-bit two's-complement pattern in its own half. No bits spill into the neighbouring half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_id | input | ID_W | Neuron identifier |
| cmd_volt | input | V_W | Signed membrane potential |
| mem_bank | output | ID_W-LOCAL_W | Bank select |
| mem_addr | output | LOCAL_W-1 | Word address inside the bank |
| mem_rd_en | output | 1 | Read strobe; data valid next cycle |
| mem_rdata | input | 2*V_W | Read data |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | 2*V_W | Merged word to write |
| done | output | 1 | One-cycle pulse at the end of an update |

## Verification
The bench builds the block with ID_W=8 and LOCAL_W=5, keeping V_W at 36. This gives 8 banks of 16 words. The bench models that memory in full, so random identifiers land on every bank and often on both halves of the same word. The narrow bank field still exercises the shift between bank and in-bank index. The full 36-bit voltage width keeps sign-bit spill into the neighbouring half observable.

// File: rtl/nstate_rmw.sv
module nstate_rmw #(
  parameter int ID_W    = 17,
  parameter int V_W     = 36,
  parameter int LOCAL_W = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic [ID_W-1:0]         cmd_id,
  input  logic [V_W-1:0]          cmd_volt,
  output logic [ID_W-LOCAL_W-1:0] mem_bank,
  output logic [LOCAL_W-2:0]      mem_addr,
  output logic                    mem_rd_en,
  input  logic [2*V_W-1:0]        mem_rdata,
  output logic                    mem_wr_en,
  output logic [2*V_W-1:0]        mem_wdata,
  output logic                    done
);
  localparam int WORD_W = 2 * V_W;

  typedef enum logic [2:0] {S_IDLE, S_READ, S_WAIT, S_WRITE, S_DONE} st_t;

  st_t               st;
  logic [ID_W-1:0]   id_q;
  logic [V_W-1:0]    v_q;
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      id_q   <= '0;
      v_q    <= '0;
      word_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (cmd_valid) begin
          id_q <= cmd_id;
          v_q  <= cmd_volt;
          st   <= S_READ;
        end
        S_READ:  st <= S_WAIT;
        S_WAIT: begin
          word_q <= id_q[0] ? {v_q, mem_rdata[V_W-1:0]}
                            : {mem_rdata[WORD_W-1:V_W], v_q};
          st     <= S_WRITE;
        end
        S_WRITE: st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready = (st == S_IDLE);
  assign mem_rd_en = (st == S_READ);
  assign mem_wr_en = (st == S_WRITE);
  assign done      = (st == S_DONE);
  assign mem_bank  = id_q[ID_W-1:LOCAL_W];
  assign mem_addr  = id_q[LOCAL_W-1:1];
  assign mem_wdata = word_q;
endmodule

// File: rtl/nstate_rmw_chk.sv
module nstate_rmw_chk #(
  parameter int ID_W    = 17,
  parameter int V_W     = 36,
  parameter int LOCAL_W = 13
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cmd_valid,
  input logic                    cmd_ready,
  input logic [ID_W-LOCAL_W-1:0] mem_bank,
  input logic [LOCAL_W-2:0]      mem_addr,
  input logic                    mem_rd_en,
  input logic [2*V_W-1:0]        mem_rdata,
  input logic                    mem_wr_en,
  input logic [2*V_W-1:0]        mem_wdata,
  input logic                    done
);
  p_rd_after_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> mem_rd_en);

  p_wr_after_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> ##1 mem_wr_en);

  p_done_after_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> (done && !mem_wr_en));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_not_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || mem_wr_en || done) |-> !cmd_ready);

  p_addr_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && $past(mem_rd_en, 2)) |->
      (mem_addr == $past(mem_addr, 2) && mem_bank == $past(mem_bank, 2)));

  p_keep_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && $past(mem_rd_en, 2)) |->
      (mem_wdata[V_W-1:0] == $past(mem_rdata[V_W-1:0]) ||
       mem_wdata[2*V_W-1:V_W] == $past(mem_rdata[2*V_W-1:V_W])));
endmodule

bind nstate_rmw nstate_rmw_chk #(.ID_W(ID_W), .V_W(V_W), .LOCAL_W(LOCAL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .mem_bank(mem_bank), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
  .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata),
  .done(done)
);

// File: tb/nstate_rmw_test.sv
module nstate_rmw_test;
  localparam int ID_W = 8, V_W = 36, LOCAL_W = 5;
  localparam int NW = 1 << (ID_W - 1);

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_ready;
  logic [ID_W-1:0] cmd_id = '0;
  logic [V_W-1:0] cmd_volt = '0;
  logic [ID_W-LOCAL_W-1:0] mem_bank;
  logic [LOCAL_W-2:0] mem_addr;
  logic mem_rd_en, mem_wr_en, done;
  logic [2*V_W-1:0] mem_rdata = '0, mem_wdata;

  logic [2*V_W-1:0] mem [NW];
  logic [V_W-1:0] sh [2*NW];
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  nstate_rmw #(.ID_W(ID_W), .V_W(V_W), .LOCAL_W(LOCAL_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_id(cmd_id), .cmd_volt(cmd_volt), .mem_bank(mem_bank), .mem_addr(mem_addr),
    .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata), .done(done));

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[{mem_bank, mem_addr}];
    if (mem_wr_en) mem[{mem_bank, mem_addr}] <= mem_wdata;
  end

  function automatic logic [2*V_W-1:0] exp_word(input logic [ID_W-1:0] id);
    int e = {id[ID_W-1:1], 1'b0};
    return {sh[e+1], sh[e]};
  endfunction

  function automatic logic [V_W-1:0] rnd36();
    return {$urandom, $urandom};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [2*V_W-1:0] act,
                     input logic [2*V_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic follow(input logic [ID_W-1:0] id, input logic [V_W-1:0] v);
    chk(!cmd_ready, "R6", cmd_ready, 0);
    chk(mem_rd_en, "R5", mem_rd_en, 1);
    chk(mem_bank == id / (1 << LOCAL_W), "R2", mem_bank, id / (1 << LOCAL_W));
    chk(mem_addr == (id % (1 << LOCAL_W)) / 2, "R2", mem_addr, (id % (1 << LOCAL_W)) / 2);
    sh[id] = v;
    @(negedge clk);
    chk(!mem_wr_en && !cmd_ready, "R5", mem_wr_en, 0);
    @(negedge clk);
    chk(mem_wr_en, "R5", mem_wr_en, 1);
    chk(mem_wdata == exp_word(id), "R3", mem_wdata, exp_word(id));
    chk(mem_bank == id / (1 << LOCAL_W), "R2", mem_bank, id / (1 << LOCAL_W));
    @(negedge clk);
    chk(done && !mem_wr_en, "R5", done, 1);
    chk(!cmd_ready, "R6", cmd_ready, 0);
    chk(mem[id / 2] == exp_word(id), "R4", mem[id / 2], exp_word(id));
  endtask

  task automatic send(input logic [ID_W-1:0] id, input logic [V_W-1:0] v);
    @(negedge clk);
    cmd_valid = 1; cmd_id = id; cmd_volt = v;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
    follow(id, v);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int w = 0; w < NW; w++) begin
      mem[w] = {rnd36(), rnd36()};
      sh[2*w] = mem[w][V_W-1:0];
      sh[2*w+1] = mem[w][2*V_W-1:V_W];
    end
    repeat (3) @(negedge clk);
    chk(cmd_ready && !done && !mem_rd_en && !mem_wr_en, "R1",
        {cmd_ready, done, mem_rd_en, mem_wr_en}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready && !done, "R1", {cmd_ready, done}, 2'b10);

    send(8'd42, 36'd1000);
    send(8'd43, 36'h0_0000_0005);
    send(8'd10, 36'd777);
    send(8'd11, -36'sd500);
    chk(mem[5][2*V_W-1] == 1'b1 && mem[5][V_W-1:0] == 36'd777, "R9 R8",
        mem[5], {-36'sd500, 36'd777});
    send(8'd255, {1'b1, 35'h0});
    chk(mem[127][2*V_W-1:V_W] == {1'b1, 35'h0}, "R9", mem[127], exp_word(8'd255));
    send(8'd0, 36'h7_FFFF_FFFF);

    @(negedge clk);
    cmd_valid = 1; cmd_id = 8'd100; cmd_volt = 36'd11;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_id = 8'd101; cmd_volt = 36'd22;
    follow(8'd100, 36'd11);
    @(negedge clk);
    chk(cmd_ready && cmd_valid, "R7", cmd_ready, 1);
    @(negedge clk);
    cmd_valid = 0;
    follow(8'd101, 36'd22);
    chk(mem[50] == {36'd22, 36'd11}, "R7 R8", mem[50], {36'd22, 36'd11});

    for (int i = 0; i < 200; i++) begin
      logic [ID_W-1:0] id = $urandom;
      if (i % 3 == 0) begin
        send({id[ID_W-1:1], 1'b0}, rnd36());
        send({id[ID_W-1:1], 1'b1}, rnd36());
      end else send(id, rnd36());
      if ($urandom % 4 == 0) repeat ($urandom % 3) @(negedge clk);
    end
    for (int w = 0; w < NW; w++)
      chk(mem[w] == {sh[2*w+1], sh[2*w]}, "R4", mem[w], {sh[2*w+1], sh[2*w]});

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule